// File: doc/BRIEF.md
# Row/Column Register Port for Video Memory

This block lets a slow CPU reach a separate video memory through four byte-wide registers instead of a memory-mapped frame buffer. The CPU loads a column and a row. Hardware turns the pair into a linear video address. Bytes written to the data register are stored at that address, and reads of the data register fetch the stored byte. After every data access the position moves one step. A control register selects whether the step goes along X or Y, and whether it goes up or down. Software can therefore stream a horizontal or vertical run of cells after setting the start point once.

The display has priority over the CPU. The port touches video memory only while the blank flag is high. Each data access is held in a one-entry buffer, and the ready flag stays low until that access has been carried out during a blanking cycle. Register strobes are single-cycle pulses and are taken only while ready is high. A read result appears on the read-data output from the first cycle in which ready is high again.

Top module: `vreg_port`

## Requirements
- R1: After reset, column, row and control read back as 0, ready is high, and neither memory strobe is active.
- R2: The memory address driven during an access is row*COLS + column (80 columns by default).
- R3: A write to register 2 raises the write strobe only in a cycle with blank high. Ready is low from the cycle after the CPU strobe until the edge that commits the write.
- R4: A read of register 2 raises the read strobe only in a cycle with blank high. Memory returns the byte one cycle later. Ready then rises, and the read-data output carries that byte.
- R5: Register 0 (column), 1 (row) and 3 (control, 2 bits) read back their stored values in the cycle after the read strobe, and ready stays high.
- R6: With control bit 0 = 0 and bit 1 = 0, each data access increments the column, and column COLS-1 wraps to 0.
- R7: With control bit 0 = 0 and bit 1 = 1, each data access decrements the column, and column 0 wraps to COLS-1.
- R8: With control bit 0 = 1, each data access steps the row: upward (bit 1 = 0) from ROWS-1 to 0, or downward (bit 1 = 1) from 0 to ROWS-1.
- R9: The position steps only after the pending memory access has completed, so the address stays fixed while an access waits.
- R10: CPU strobes that arrive while ready is low have no effect.
- R11: A column write of a value ≥ COLS, or a row write of a value ≥ ROWS, leaves that register unchanged.
- R12: The write and read strobes to memory are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_sel_i | input | 1 | Port selected by CPU |
| cpu_addr_i | input | 2 | Register index: 0 column, 1 row, 2 data, 3 control |
| cpu_wr_i | input | 1 | Write strobe |
| cpu_rd_i | input | 1 | Read strobe |
| cpu_wdata_i | input | DW | Write data |
| cpu_rdata_o | output | DW | Result of the last accepted read |
| cpu_ready_o | output | 1 | High when the port can take a strobe |
| blank_i | input | 1 | Display is blanking; memory may be used |
| vm_addr_o | output | AW | Video memory address |
| vm_we_o | output | 1 | Video memory write strobe |
| vm_re_o | output | 1 | Video memory read strobe (data returned next cycle) |
| vm_wdata_o | output | DW | Video memory write data |
| vm_rdata_i | input | DW | Video memory read data |

## Verification
The hardest case is a CPU strobe that arrives while an access is still waiting for blanking. Such a strobe must be dropped, and the waiting access must still commit to the position it saw when it was queued. The bench holds blank low, queues a data write, and then drives a column write while ready is low. Only after that does it open blanking. It then checks where the byte landed and what the column reads back. The wrap cases are reached by placing the position on the edge cell before a single data access in each step mode.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD, ST_FETCH} vrp_state_e;
  typedef enum logic [1:0] {
    REG_COL  = 2'd0,
    REG_ROW  = 2'd1,
    REG_DATA = 2'd2,
    REG_CTRL = 2'd3
  } vrp_reg_e;
endpackage

// File: rtl/vrp_pos.sv
module vrp_pos #(
  parameter int COLS = 80,
  parameter int ROWS = 60,
  parameter int DW   = 8,
  localparam int CW  = $clog2(COLS),
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          col_we_i,
  input  logic          row_we_i,
  input  logic          ctl_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          step_i,
  output logic [CW-1:0] col_o,
  output logic [RW-1:0] row_o,
  output logic          step_y_o,
  output logic          step_dec_o
);
  logic [CW-1:0] col_nx;
  logic [RW-1:0] row_nx;
  logic          col_ok, row_ok;

  assign col_ok = 32'(wdata_i) < COLS;
  assign row_ok = 32'(wdata_i) < ROWS;

  always_comb begin
    col_nx = col_o;
    row_nx = row_o;
    if (!step_y_o) begin
      if (step_dec_o) col_nx = (col_o == '0) ? CW'(COLS-1) : col_o - 1'b1;
      else            col_nx = (col_o == CW'(COLS-1)) ? '0 : col_o + 1'b1;
    end else begin
      if (step_dec_o) row_nx = (row_o == '0) ? RW'(ROWS-1) : row_o - 1'b1;
      else            row_nx = (row_o == RW'(ROWS-1)) ? '0 : row_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o      <= '0;
      row_o      <= '0;
      step_y_o   <= 1'b0;
      step_dec_o <= 1'b0;
    end else begin
      if (step_i) begin
        col_o <= col_nx;
        row_o <= row_nx;
      end else begin
        if (col_we_i && col_ok) col_o <= wdata_i[CW-1:0];
        if (row_we_i && row_ok) row_o <= wdata_i[RW-1:0];
      end
      if (ctl_we_i) begin
        step_y_o   <= wdata_i[0];
        step_dec_o <= wdata_i[1];
      end
    end
  end
endmodule

// File: rtl/vrp_addr.sv
module vrp_addr #(
  parameter int COLS = 80,
  parameter int ROWS = 60,
  localparam int CW  = $clog2(COLS),
  localparam int RW  = $clog2(ROWS),
  localparam int AW  = $clog2(COLS*ROWS)
) (
  input  logic [CW-1:0] col_i,
  input  logic [RW-1:0] row_i,
  output logic [AW-1:0] addr_o
);
  assign addr_o = AW'(row_i) * AW'(COLS) + AW'(col_i);
endmodule

// File: rtl/vrp_ctrl.sv
module vrp_ctrl
  import vrp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_wr_i,
  input  logic acc_rd_i,
  input  logic blank_i,
  output logic ready_o,
  output logic mem_we_o,
  output logic mem_re_o,
  output logic capture_o,
  output logic step_o
);
  vrp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (acc_wr_i) st_d = ST_WR; else if (acc_rd_i) st_d = ST_RD;
      ST_WR:    if (blank_i) st_d = ST_IDLE;
      ST_RD:    if (blank_i) st_d = ST_FETCH;
      ST_FETCH: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign ready_o   = (st_q == ST_IDLE);
  assign mem_we_o  = (st_q == ST_WR) && blank_i;
  assign mem_re_o  = (st_q == ST_RD) && blank_i;
  assign capture_o = (st_q == ST_FETCH);
  // step after the access has finished
  assign step_o    = mem_we_o || capture_o;
endmodule

// File: rtl/vreg_port.sv
module vreg_port
  import vrp_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 60,
  parameter int DW   = 8,
  localparam int CW  = $clog2(COLS),
  localparam int RW  = $clog2(ROWS),
  localparam int AW  = $clog2(COLS*ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_sel_i,
  input  logic [1:0]    cpu_addr_i,
  input  logic          cpu_wr_i,
  input  logic          cpu_rd_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          cpu_ready_o,
  input  logic          blank_i,
  output logic [AW-1:0] vm_addr_o,
  output logic          vm_we_o,
  output logic          vm_re_o,
  output logic [DW-1:0] vm_wdata_o,
  input  logic [DW-1:0] vm_rdata_i
);
  logic          acc, wr_acc, rd_acc, data_wr, data_rd;
  logic          capture, step;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          step_y, step_dec;
  logic [DW-1:0] wbuf_q, rdata_q, reg_mux;
  vrp_reg_e      sel_reg;

  assign sel_reg = vrp_reg_e'(cpu_addr_i);
  assign acc     = cpu_sel_i && cpu_ready_o;
  assign wr_acc  = acc && cpu_wr_i;
  assign rd_acc  = acc && cpu_rd_i && !cpu_wr_i;
  assign data_wr = wr_acc && (sel_reg == REG_DATA);
  assign data_rd = rd_acc && (sel_reg == REG_DATA);

  vrp_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_wr_i  (data_wr),
    .acc_rd_i  (data_rd),
    .blank_i   (blank_i),
    .ready_o   (cpu_ready_o),
    .mem_we_o  (vm_we_o),
    .mem_re_o  (vm_re_o),
    .capture_o (capture),
    .step_o    (step)
  );

  vrp_pos #(.COLS(COLS), .ROWS(ROWS), .DW(DW)) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .col_we_i   (wr_acc && (sel_reg == REG_COL)),
    .row_we_i   (wr_acc && (sel_reg == REG_ROW)),
    .ctl_we_i   (wr_acc && (sel_reg == REG_CTRL)),
    .wdata_i    (cpu_wdata_i),
    .step_i     (step),
    .col_o      (col),
    .row_o      (row),
    .step_y_o   (step_y),
    .step_dec_o (step_dec)
  );

  vrp_addr #(.COLS(COLS), .ROWS(ROWS)) u_addr (
    .col_i  (col),
    .row_i  (row),
    .addr_o (vm_addr_o)
  );

  always_comb begin
    reg_mux = '0;
    unique case (sel_reg)
      REG_COL:  reg_mux = DW'(col);
      REG_ROW:  reg_mux = DW'(row);
      REG_CTRL: reg_mux = DW'({step_dec, step_y});
      default:  reg_mux = rdata_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbuf_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (data_wr) wbuf_q <= cpu_wdata_i;
      if (capture)                      rdata_q <= vm_rdata_i;
      else if (rd_acc && !data_rd)      rdata_q <= reg_mux;
    end
  end

  assign vm_wdata_o  = wbuf_q;
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/vreg_port_chk.sv
module vreg_port_chk #(
  parameter int COLS = 80,
  parameter int ROWS = 60,
  localparam int AW  = $clog2(COLS*ROWS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          blank_i,
  input logic          cpu_ready_o,
  input logic          vm_we_o,
  input logic          vm_re_o,
  input logic [AW-1:0] vm_addr_o
);
  AST_WE_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vm_we_o |-> blank_i); // R3
  AST_ACCESS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vm_we_o || vm_re_o) |-> !cpu_ready_o); // R3
  AST_WE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vm_we_o |=> cpu_ready_o); // R3
  AST_RE_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vm_re_o |-> blank_i); // R4
  AST_READY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_ready_o) |-> ($past(vm_we_o) || $past(vm_re_o, 2))); // R4
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vm_we_o || vm_re_o) |-> (32'(vm_addr_o) < COLS*ROWS)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_ready_o && !vm_we_o && !vm_re_o && !$past(vm_re_o)) |=> $stable(vm_addr_o)); // R9
  AST_NO_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vm_we_o && vm_re_o)); // R12
endmodule

bind vreg_port vreg_port_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blank_i     (blank_i),
  .cpu_ready_o (cpu_ready_o),
  .vm_we_o     (vm_we_o),
  .vm_re_o     (vm_re_o),
  .vm_addr_o   (vm_addr_o)
);

// File: tb/sim_vreg_port.sv
`timescale 1ns/1ps
module sim_vreg_port;
  localparam int COLS = 80;
  localparam int ROWS = 60;
  localparam int DW   = 8;
  localparam int AW   = $clog2(COLS*ROWS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, wr = 1'b0, rd = 1'b0, blank = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, vm_wdata, vm_rdata;
  logic          ready, vm_we, vm_re;
  logic [AW-1:0] vm_addr;
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  vreg_port #(.COLS(COLS), .ROWS(ROWS), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_sel_i(sel), .cpu_addr_i(addr),
    .cpu_wr_i(wr), .cpu_rd_i(rd), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .cpu_ready_o(ready), .blank_i(blank), .vm_addr_o(vm_addr),
    .vm_we_o(vm_we), .vm_re_o(vm_re), .vm_wdata_o(vm_wdata), .vm_rdata_i(vm_rdata)
  );

  // video memory model, registered read
  always @(posedge clk) begin
    if (vm_we) mem[vm_addr] <= vm_wdata;
    if (vm_re) vm_rdata <= mem[vm_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual hung, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input int d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = DW'(d);
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output int d);
    @(negedge clk);
    sel = 1; rd = 1; addr = a;
    @(negedge clk);
    sel = 0; rd = 0;
    wait_ready();
    d = int'(rdata);
  endtask

  task automatic set_pos(input int c, input int r, input int ct);
    bus_wr(2'd0, c); bus_wr(2'd1, r); bus_wr(2'd3, ct);
  endtask

  task automatic t_reset();
    int v;
    check("R1 ready", int'(ready), 1);
    check("R1 we", int'(vm_we), 0);
    check("R1 re", int'(vm_re), 0);
    bus_rd(2'd0, v); check("R1 column", v, 0);
    bus_rd(2'd1, v); check("R1 row", v, 0);
    bus_rd(2'd3, v); check("R1 control", v, 0);
  endtask

  task automatic t_regs();
    int v;
    set_pos(5, 7, 3);
    @(negedge clk); sel = 1; rd = 1; addr = 2'd1;
    @(negedge clk); sel = 0; rd = 0;
    check("R5 ready stays high", int'(ready), 1);
    check("R5 row next cycle", int'(rdata), 7);
    bus_rd(2'd0, v); check("R5 column", v, 5);
    bus_rd(2'd3, v); check("R5 control", v, 3);
  endtask

  task automatic t_range();
    int v;
    bus_wr(2'd0, COLS); bus_rd(2'd0, v); check("R11 column >= COLS", v, 5);
    bus_wr(2'd1, ROWS); bus_rd(2'd1, v); check("R11 row >= ROWS", v, 7);
    bus_wr(2'd0, COLS-1); bus_rd(2'd0, v); check("R11 column max accepted", v, COLS-1);
  endtask

  task automatic t_write_defer();
    int v, seen_we = 0;
    blank = 0;
    set_pos(10, 2, 0);
    bus_wr(2'd2, 8'hA5);
    for (int i = 0; i < 5; i++) begin
      if (vm_we) seen_we = 1;
      @(negedge clk);
    end
    check("R3 no write outside blank", seen_we, 0);
    check("R3 ready low while pending", int'(ready), 0);
    blank = 1;
    #1;
    check("R3 write strobe in blank", int'(vm_we), 1);
    check("R2 address row*80+col", int'(vm_addr), 2*COLS + 10);
    check("R12 no read with write", int'(vm_re), 0);
    @(negedge clk);
    check("R3 ready after commit", int'(ready), 1);
    blank = 0;
    check("R3 stored byte", int'(mem[2*COLS+10]), 8'hA5);
    bus_rd(2'd0, v); check("R9 column stepped once", v, 11);
  endtask

  task automatic t_read();
    int v, seen_re = 0;
    mem[3*COLS+4] = 8'h3C;
    blank = 0;
    set_pos(4, 3, 0);
    @(negedge clk); sel = 1; rd = 1; addr = 2'd2;
    @(negedge clk); sel = 0; rd = 0;
    for (int i = 0; i < 4; i++) begin
      if (vm_re) seen_re = 1;
      @(negedge clk);
    end
    check("R4 no read outside blank", seen_re, 0);
    check("R4 ready low while pending", int'(ready), 0);
    blank = 1;
    wait_ready();
    blank = 0;
    check("R4 read data", int'(rdata), 8'h3C);
    bus_rd(2'd0, v); check("R4 column stepped after read", v, 5);
  endtask

  task automatic t_wrap();
    int v;
    blank = 1;
    set_pos(COLS-1, 1, 0); bus_wr(2'd2, 8'h11); wait_ready();
    bus_rd(2'd0, v); check("R6 column wraps to 0", v, 0);
    check("R6 byte at last column", int'(mem[COLS+COLS-1]), 8'h11);
    set_pos(0, 1, 2); bus_wr(2'd2, 8'h22); wait_ready();
    bus_rd(2'd0, v); check("R7 column wraps to max", v, COLS-1);
    set_pos(6, ROWS-1, 1); bus_wr(2'd2, 8'h33); wait_ready();
    bus_rd(2'd1, v); check("R8 row wraps to 0", v, 0);
    check("R2 last row address", int'(mem[(ROWS-1)*COLS+6]), 8'h33);
    set_pos(6, 0, 3); bus_wr(2'd2, 8'h44); wait_ready();
    bus_rd(2'd1, v); check("R8 row wraps to max", v, ROWS-1);
    set_pos(3, 10, 1);
    for (int i = 0; i < 3; i++) begin
      bus_wr(2'd2, 8'h50 + i); wait_ready();
    end
    for (int i = 0; i < 3; i++)
      check("R8 vertical stream", int'(mem[(10+i)*COLS+3]), 8'h50 + i);
    blank = 0;
  endtask

  task automatic t_ignore();
    int v;
    blank = 0;
    set_pos(20, 4, 0);
    bus_wr(2'd2, 8'h77);
    bus_wr(2'd0, 9);
    bus_wr(2'd3, 3);
    blank = 1;
    wait_ready();
    blank = 0;
    check("R10 byte at queued position", int'(mem[4*COLS+20]), 8'h77);
    bus_rd(2'd0, v); check("R10 column write dropped", v, 21);
    bus_rd(2'd3, v); check("R10 control write dropped", v, 0);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_range();
    t_write_defer();
    t_read();
    t_wrap();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule